// File: doc/BRIEF.md
# Tone Transceiver Host Register Interface

This block is the host-facing register file and bus adapter of a tone-signalling transceiver. A microprocessor reaches it over a 4-bit data bus. Access is qualified by an active-low chip select and steered by a single register-select line. A static strap picks the strobe convention. The split convention uses separate active-low read and write strobes. The qualified convention uses a read/write level that an active-high data strobe qualifies. All bus inputs are sampled on the core clock. A write takes effect on the first clock edge at which the access is seen. Read side effects take effect on the edge after the read strobe is removed.

The block holds five things: a write-only digit register that selects the tone pair to transmit, a read-only register holding the last validated received digit, two control registers, and a status word. Both control registers share one address. A pointer bit sends the next control write to the second register. The tone-side logic supplies a one-cycle valid-digit strobe with its code, a one-cycle transmitter-ready pulse and a squared call-progress level. One open-drain output serves either as the interrupt or as a call-progress square wave. It is modelled as a pull-down enable, where 1 means the pin is pulled low.

Top module: `tone_host_regs`

## Requirements
- R1: A write with `rsel`=0 loads `data_in` into the transmit digit register, and `tx_code` shows the new value after that edge.
- R2: A read with `rsel`=0 drives the code of the most recent validated digit on `data_out` with `data_oe`=1. `data_oe` is never 1 while `cs_n` is high.
- R3: Writes with `rsel`=1 go to control A, whose bit 3 is the pointer flag. A control A write with bit 3 set sends the next control write to control B. Every control write after that one goes to control A again.
- R4: After reset both control registers read 0, the pointer selects control A, `irq_oe` is 0 and the status word is 4'b0010.
- R5: A read with `rsel`=1 returns status: bit 0 interrupt pending, bit 1 transmit register empty, bit 2 receive register full, bit 3 set in the cycle after a digit is validated.
- R6: A validated digit sets the pending interrupt only while control A bit 2 (interrupt enable) is 1. A pending interrupt pulls `irq_oe` to 1.
- R7: A transmitter-ready pulse sets the pending interrupt only while control B bit 0 (burst mode) and the interrupt enable are both 1.
- R8: The end of a status read clears the pending interrupt and releases `irq_oe`.
- R9: The end of a receive-register read clears the receive-full status bit.
- R10: While control A bit 1 (call-progress mode) is 1, `irq_oe` equals the inverse of `cp_in` one cycle earlier, whatever the interrupt state.
- R11: With `bus_style`=1, `rd_ds` is an active-high data strobe and `wr_rw` is a level (1 read, 0 write). With `bus_style`=0, both are active-low read and write strobes.
- R12: A transmit write clears the transmit-empty bit, and a transmitter-ready pulse sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_style | input | 1 | Strobe convention strap: 0 split strobes, 1 qualified strobe |
| cs_n | input | 1 | Active-low chip select |
| rsel | input | 1 | Register select: 0 digit registers, 1 control/status |
| rd_ds | input | 1 | Read strobe (active low) or data strobe (active high) |
| wr_rw | input | 1 | Write strobe (active low) or read/write level |
| data_in | input | 4 | Host write data |
| data_out | output | 4 | Host read data |
| data_oe | output | 1 | Read data drive enable |
| rx_valid | input | 1 | One-cycle strobe from the detector: a digit was validated |
| rx_code | input | 4 | Code of the validated digit |
| tx_ready | input | 1 | One-cycle pulse: the transmitter can take a new digit |
| cp_in | input | 1 | Squared call-progress level |
| tx_code | output | 4 | Transmit digit register contents |
| ctrl_a | output | 4 | Control register A contents |
| ctrl_b | output | 4 | Control register B contents |
| irq_oe | output | 1 | Pull-down enable of the shared open-drain pin |

## Verification
Register writes land on the first clock edge of the strobe. `tx_code`, `ctrl_a` and `ctrl_b` are checked one edge after the strobe is raised. Read data is combinational from the strobe and is sampled on the falling clock edge inside the strobe. Clears caused by a read are looked for one edge after the strobe is removed. The detector pulses last one cycle. The interrupt pin is checked right after the edge that captured them. The status read that looks for the one-cycle steering bit is started in the cycle just after the validation edge. In call-progress mode, the pin is checked one edge after each change of `cp_in`.

// File: rtl/tone_host_pkg.sv
package tone_host_pkg;
  localparam int DW = 4;

  // control A fields
  localparam int CA_TONE_EN = 0;
  localparam int CA_CP_MODE = 1;
  localparam int CA_IRQ_EN  = 2;
  localparam int CA_SEL_B   = 3;

  // control B fields
  localparam int CB_BURST   = 0;
  localparam int CB_TEST    = 1;
  localparam int CB_SINGLE  = 2;
  localparam int CB_COLROW  = 3;

  // status fields
  localparam int ST_IRQ     = 0;
  localparam int ST_TXE     = 1;
  localparam int ST_RXF     = 2;
  localparam int ST_STEER   = 3;

  typedef enum logic {
    STYLE_SPLIT = 1'b0,
    STYLE_QUAL  = 1'b1
  } bus_style_e;
endpackage

// File: rtl/tone_host_bus.sv
module tone_host_bus
  import tone_host_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic style,
  input  logic cs_n,
  input  logic rsel,
  input  logic rd_ds,
  input  logic wr_rw,
  output logic wr_tx,
  output logic wr_ctrl,
  output logic rd_rx_end,
  output logic rd_st_end,
  output logic rd_active
);
  logic rd_act, wr_act;
  logic rd_q, wr_q, rsel_q;
  logic rsel_d;
  logic wr_rise, rd_fall;

  always_comb begin
    if (bus_style_e'(style) == STYLE_QUAL) begin
      rd_act = !cs_n && rd_ds && wr_rw;
      wr_act = !cs_n && rd_ds && !wr_rw;
    end else begin
      rd_act = !cs_n && !rd_ds;
      wr_act = !cs_n && !wr_rw;
    end
  end

  // remember which register a read targets until its strobe ends
  always_comb rsel_d = rd_act ? rsel : rsel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      rsel_q <= 1'b0;
    end else begin
      rd_q   <= rd_act;
      wr_q   <= wr_act;
      rsel_q <= rsel_d;
    end
  end

  assign wr_rise   = wr_act && !wr_q;
  assign rd_fall   = rd_q && !rd_act;
  assign wr_tx     = wr_rise && !rsel;
  assign wr_ctrl   = wr_rise && rsel;
  assign rd_rx_end = rd_fall && !rsel_q;
  assign rd_st_end = rd_fall && rsel_q;
  assign rd_active = rd_act;
endmodule

// File: rtl/tone_host_ctrl.sv
module tone_host_ctrl
  import tone_host_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cra,
  output logic [DW-1:0] crb,
  output logic          sel_b
);
  logic [DW-1:0] cra_d, crb_d;
  logic          sel_d;

  always_comb begin
    cra_d = cra;
    crb_d = crb;
    sel_d = sel_b;
    if (wr_ctrl) begin
      if (sel_b) begin
        crb_d = wdata;
        sel_d = 1'b0;
      end else begin
        cra_d = wdata;
        sel_d = wdata[CA_SEL_B];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cra   <= '0;
      crb   <= '0;
      sel_b <= 1'b0;
    end else begin
      cra   <= cra_d;
      crb   <= crb_d;
      sel_b <= sel_d;
    end
  end
endmodule

// File: rtl/tone_host_flags.sv
module tone_host_flags
  import tone_host_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_tx,
  input  logic          rd_rx_end,
  input  logic          rd_st_end,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_code,
  input  logic          tx_ready,
  input  logic          cp_in,
  input  logic          irq_en,
  input  logic          burst,
  input  logic          cp_mode,
  output logic [DW-1:0] rx_data,
  output logic [DW-1:0] status,
  output logic          irq_flag,
  output logic          pin_pull
);
  logic [DW-1:0] rx_d;
  logic rxf_q, rxf_d;
  logic txe_q, txe_d;
  logic irq_d;
  logic steer_q;
  logic cp_q;
  logic irq_src;

  assign irq_src = irq_en && (rx_valid || (burst && tx_ready));

  always_comb begin
    rx_d  = rx_valid ? rx_code : rx_data;
    rxf_d = rx_valid ? 1'b1 : (rd_rx_end ? 1'b0 : rxf_q);
    txe_d = wr_tx ? 1'b0 : (tx_ready ? 1'b1 : txe_q);
    irq_d = irq_src ? 1'b1 : (rd_st_end ? 1'b0 : irq_flag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rxf_q    <= 1'b0;
      txe_q    <= 1'b1;
      irq_flag <= 1'b0;
      steer_q  <= 1'b0;
      cp_q     <= 1'b1;
    end else begin
      rx_data  <= rx_d;
      rxf_q    <= rxf_d;
      txe_q    <= txe_d;
      irq_flag <= irq_d;
      steer_q  <= rx_valid;
      cp_q     <= cp_in;
    end
  end

  always_comb begin
    status           = '0;
    status[ST_IRQ]   = irq_flag;
    status[ST_TXE]   = txe_q;
    status[ST_RXF]   = rxf_q;
    status[ST_STEER] = steer_q;
  end

  assign pin_pull = cp_mode ? !cp_q : (irq_flag && irq_en);
endmodule

// File: rtl/tone_host_regs.sv
module tone_host_regs
  import tone_host_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_style,
  input  logic          cs_n,
  input  logic          rsel,
  input  logic          rd_ds,
  input  logic          wr_rw,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_code,
  input  logic          tx_ready,
  input  logic          cp_in,
  output logic [DW-1:0] tx_code,
  output logic [DW-1:0] ctrl_a,
  output logic [DW-1:0] ctrl_b,
  output logic          irq_oe
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic rst_core_n;
  logic wr_tx, wr_ctrl, rd_rx_end, rd_st_end, rd_active;
  logic sel_b, irq_flag;
  logic [DW-1:0] rx_data, status, tx_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[SYNC_STAGES-1];

  tone_host_bus u_bus (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .style     (bus_style),
    .cs_n      (cs_n),
    .rsel      (rsel),
    .rd_ds     (rd_ds),
    .wr_rw     (wr_rw),
    .wr_tx     (wr_tx),
    .wr_ctrl   (wr_ctrl),
    .rd_rx_end (rd_rx_end),
    .rd_st_end (rd_st_end),
    .rd_active (rd_active)
  );

  tone_host_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_ctrl (wr_ctrl),
    .wdata   (data_in),
    .cra     (ctrl_a),
    .crb     (ctrl_b),
    .sel_b   (sel_b)
  );

  tone_host_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_tx     (wr_tx),
    .rd_rx_end (rd_rx_end),
    .rd_st_end (rd_st_end),
    .rx_valid  (rx_valid),
    .rx_code   (rx_code),
    .tx_ready  (tx_ready),
    .cp_in     (cp_in),
    .irq_en    (ctrl_a[CA_IRQ_EN]),
    .burst     (ctrl_b[CB_BURST]),
    .cp_mode   (ctrl_a[CA_CP_MODE]),
    .rx_data   (rx_data),
    .status    (status),
    .irq_flag  (irq_flag),
    .pin_pull  (irq_oe)
  );

  always_comb tx_d = wr_tx ? data_in : tx_code;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) tx_code <= '0;
    else             tx_code <= tx_d;
  end

  assign data_out = rsel ? status : rx_data;
  assign data_oe  = rd_active;
endmodule

// File: rtl/tone_host_chk.sv
module tone_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       data_oe,
  input logic       wbit3,
  input logic [3:0] ctrl_a,
  input logic [3:0] ctrl_b,
  input logic       cp_in,
  input logic       rx_valid,
  input logic       tx_ready,
  input logic       irq_oe,
  input logic       wr_ctrl,
  input logic       sel_b,
  input logic       irq_flag,
  input logic       rd_st_end
);
  a_r2_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !cs_n);

  a_r3_ptr_back: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && sel_b) |=> !sel_b);

  a_r3_ptr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !sel_b && wbit3) |=> sel_b);

  a_r10_cp_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_a[1] && $past(ctrl_a[1])) |-> (irq_oe == !$past(cp_in)));

  a_r8_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st_end && !rx_valid && !tx_ready) |=> !irq_flag);

  a_r7_no_burst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_a[1] && !irq_flag && !ctrl_b[0] && tx_ready && !rx_valid && !wr_ctrl)
      |=> !irq_oe);
endmodule

bind tone_host_regs tone_host_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .cs_n      (cs_n),
  .data_oe   (data_oe),
  .wbit3     (data_in[3]),
  .ctrl_a    (ctrl_a),
  .ctrl_b    (ctrl_b),
  .cp_in     (cp_in),
  .rx_valid  (rx_valid),
  .tx_ready  (tx_ready),
  .irq_oe    (irq_oe),
  .wr_ctrl   (wr_ctrl),
  .sel_b     (sel_b),
  .irq_flag  (irq_flag),
  .rd_st_end (rd_st_end)
);

// File: tb/test_tone_host_regs.sv
`timescale 1ns/1ps
module test_tone_host_regs;
  logic clk = 1'b0;
  logic rst_n, bus_style, cs_n, rsel, rd_ds, wr_rw;
  logic [3:0] data_in, data_out, rx_code, tx_code, ctrl_a, ctrl_b;
  logic data_oe, rx_valid, tx_ready, cp_in, irq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic       oe_prev = 1'b0;

  always #10 clk = ~clk;

  tone_host_regs i_tone_host_regs (
    .clk(clk), .rst_n(rst_n), .bus_style(bus_style), .cs_n(cs_n), .rsel(rsel),
    .rd_ds(rd_ds), .wr_rw(wr_rw), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .rx_valid(rx_valid), .rx_code(rx_code),
    .tx_ready(tx_ready), .cp_in(cp_in), .tx_code(tx_code), .ctrl_a(ctrl_a),
    .ctrl_b(ctrl_b), .irq_oe(irq_oe)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each read as its data appears on the bus
  always @(negedge clk) begin
    if (data_oe && !oe_prev) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected read actual=%h expected=none", data_out);
      end else begin
        automatic logic [3:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, data_out, e);
      end
    end
    oe_prev = data_oe;
  end

  task automatic idle_bus();
    cs_n = 1'b1;
    if (bus_style) begin rd_ds = 1'b0; wr_rw = 1'b1; end
    else           begin rd_ds = 1'b1; wr_rw = 1'b1; end
  endtask

  task automatic drive_read(input logic rs);
    cs_n = 1'b0; rsel = rs;
    if (bus_style) begin wr_rw = 1'b1; rd_ds = 1'b1; end
    else           rd_ds = 1'b0;
  endtask

  task automatic bus_write(input logic rs, input logic [3:0] d);
    @(posedge clk); #2;
    cs_n = 1'b0; rsel = rs; data_in = d;
    if (bus_style) begin wr_rw = 1'b0; rd_ds = 1'b1; end
    else           wr_rw = 1'b0;
    @(posedge clk); #2;
    idle_bus();
  endtask

  // driver: push expectation, run the read, wait for its side effect
  task automatic bus_read(input logic rs, input logic [3:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #2;
    drive_read(rs);
    @(posedge clk); #2;
    idle_bus();
    @(posedge clk); #2;
  endtask

  task automatic pulse_rx(input logic [3:0] code);
    @(posedge clk); #2;
    rx_valid = 1'b1; rx_code = code;
    @(posedge clk); #2;
    rx_valid = 1'b0;
  endtask

  task automatic pulse_txr();
    @(posedge clk); #2;
    tx_ready = 1'b1;
    @(posedge clk); #2;
    tx_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; bus_style = 1'b0; rsel = 1'b0; data_in = '0;
    rx_valid = 1'b0; rx_code = '0; tx_ready = 1'b0; cp_in = 1'b1;
    idle_bus();
    repeat (3) @(posedge clk); #2;
    check("R4 ctrl_a in reset", ctrl_a, 4'h0);
    check("R4 ctrl_b in reset", ctrl_b, 4'h0);
    check("R4 pin in reset", {3'b0, irq_oe}, 4'h0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk); #2;
    bus_read(1'b1, 4'b0010, "R4 status after reset");

    // R3 pointer routing
    bus_write(1'b1, 4'b0001);
    check("R3 first write to A", ctrl_a, 4'b0001);
    check("R3 B untouched", ctrl_b, 4'b0000);
    bus_write(1'b1, 4'b1100);
    check("R3 A with flag", ctrl_a, 4'b1100);
    bus_write(1'b1, 4'b0001);
    check("R3 write lands in B", ctrl_b, 4'b0001);
    check("R3 A kept", ctrl_a, 4'b1100);
    bus_write(1'b1, 4'b0100);
    check("R3 pointer back to A", ctrl_a, 4'b0100);
    check("R3 B kept", ctrl_b, 4'b0001);

    // R1 / R12 transmit register
    bus_write(1'b0, 4'h7);
    check("R1 tx_code", tx_code, 4'h7);
    bus_read(1'b1, 4'b0000, "R12 tx empty cleared");

    // R7 burst interrupt, R8 clear
    pulse_txr();
    check("R7 burst irq pin", {3'b0, irq_oe}, 4'h1);
    bus_read(1'b1, 4'b0011, "R7 status after ready");
    check("R8 pin released", {3'b0, irq_oe}, 4'h0);
    bus_read(1'b1, 4'b0010, "R8 flag cleared");

    // R6 digit interrupt, R2 / R9
    pulse_rx(4'h9);
    check("R6 digit irq pin", {3'b0, irq_oe}, 4'h1);
    bus_read(1'b1, 4'b0111, "R6 status after digit");
    check("R8 pin released after digit", {3'b0, irq_oe}, 4'h0);
    bus_read(1'b0, 4'h9, "R2 receive code");
    bus_read(1'b1, 4'b0010, "R9 rx full cleared");

    // R7 without burst
    bus_write(1'b1, 4'b1100);
    bus_write(1'b1, 4'b0000);
    check("R7 burst off", ctrl_b, 4'b0000);
    pulse_txr();
    check("R7 no irq without burst", {3'b0, irq_oe}, 4'h0);
    bus_read(1'b1, 4'b0010, "R7 no pending flag");

    // R6 disabled
    bus_write(1'b1, 4'b0000);
    pulse_rx(4'h5);
    check("R6 no irq when disabled", {3'b0, irq_oe}, 4'h0);
    bus_read(1'b1, 4'b0110, "R6 status rx full only");
    bus_read(1'b0, 4'h5, "R2 second code");

    // R5 steering bit: read starts in the cycle after validation
    @(posedge clk); #2;
    rx_valid = 1'b1; rx_code = 4'h3;
    @(posedge clk); #2;
    rx_valid = 1'b0;
    exp_q.push_back(4'b1110); tag_q.push_back("R5 steer bit");
    drive_read(1'b1);
    @(posedge clk); #2;
    idle_bus();
    @(posedge clk); #2;
    bus_read(1'b0, 4'h3, "R5 code behind steer");

    // R10 call-progress mode
    bus_write(1'b1, 4'b0010);
    @(posedge clk); #2;
    check("R10 cp high -> released", {3'b0, irq_oe}, 4'h0);
    cp_in = 1'b0;
    @(posedge clk); #2;
    check("R10 cp low -> pulled", {3'b0, irq_oe}, 4'h1);
    cp_in = 1'b1;
    @(posedge clk); #2;
    check("R10 cp high again", {3'b0, irq_oe}, 4'h0);
    bus_write(1'b1, 4'b0110);
    pulse_rx(4'hC);
    check("R10 irq masked by cp mode", {3'b0, irq_oe}, 4'h0);
    bus_read(1'b1, 4'b0111, "R10 flag still recorded");
    bus_read(1'b0, 4'hC, "R10 code");
    bus_write(1'b1, 4'b0000);

    // R11 qualified strobe style
    bus_style = 1'b1;
    idle_bus();
    @(posedge clk); #2;
    bus_write(1'b0, 4'hA);
    check("R11 qualified tx write", tx_code, 4'hA);
    bus_write(1'b1, 4'b0001);
    check("R11 qualified ctrl write", ctrl_a, 4'b0001);
    pulse_rx(4'hB);
    bus_read(1'b0, 4'hB, "R11 qualified rx read");
    bus_read(1'b1, 4'b0000, "R11 qualified status");
    @(posedge clk); #2;
    rd_ds = 1'b1; wr_rw = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    check("R11 no drive without select", {3'b0, data_oe}, 4'h0);
    @(posedge clk); #2;
    idle_bus();
    @(posedge clk); #2;

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 reads pending actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule